// File: doc/BRIEF.md
# Serial Word Sequencer

This block is a synchronous source of serial data. A small read-only table of words, filled by a formula at elaboration, is read one word at a time. Each word is loaded into a shift register and sent out one bit per clock, least significant bit first. There are no idle clocks between words, so exactly one word leaves every `WORD_W` clocks. An address pointer normally steps through the table in order and wraps at the end. A jump request redirects the pointer to any table address, starting at the next word boundary.

The block supplies test or program streams to serial datapaths. The word phase depends only on the number of clocks since reset was released. Two copies released from reset on the same edge therefore present aligned operand streams, for example the two inputs of a bit-serial ALU.

Top module: `serial_word_source`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low, and in the clock after each edge that samples it low, `cur_addr` is 0, `frame` is 0 and `ser_bit` is 0. The first clock edge with `rst_n` high loads table word 0. Bit 0 of that word is presented immediately after that edge.
- R2: The bit presented k clocks after a `frame` clock (k = 0 .. WORD_W-1) is bit k of the current word, least significant bit first.
- R3: `frame` is high for exactly one clock per word: the clock in which bit 0 is presented. Consecutive `frame` pulses are exactly WORD_W clocks apart, with no gap between words.
- R4: With no jump pending, each word comes from the address one above the previous word's address.
- R5: `cur_addr` holds the address of the word being shifted out, and stays constant for all WORD_W clocks of that word.
- R6: A `jump_req` sampled high on a clock edge that is not a word boundary is remembered. The next word then comes from that request's `jump_addr`, and the words after it follow from jump_addr+1. If several requests arrive within one word, the latest one wins.
- R7: A `jump_req` sampled on the boundary edge takes effect at that same boundary. The boundary edge is the edge that ends the clock presenting the last bit (bit WORD_W-1). This request overrides any request still pending.
- R8: Table word i equals ((i*157 + 59) XOR (i << WORD_W/2)), reduced modulo 2^WORD_W.
- R9: The address after 2^ADDR_W-1 is 0.
- R10: The word width is a parameter. With WORD_W=16 a word leaves every 16 clocks. A 16-bit copy and an 8-bit copy released from reset on the same edge have every 16-bit `frame` pulse fall in the same clock as an 8-bit `frame` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| jump_req | input | 1 | Request to continue from `jump_addr` at the next word boundary |
| jump_addr | input | ADDR_W | Target table address for a jump |
| ser_bit | output | 1 | Serial data, LSB first |
| frame | output | 1 | High while bit 0 of a word is presented |
| cur_addr | output | ADDR_W | Table address of the word being shifted out |

## Verification
Every output follows the boundary edge by one register: the word fetched on the boundary edge appears with `frame` and bit 0 in the clock right after that edge. A jump request therefore shows up in `cur_addr` one clock after the next boundary edge, or one clock after the request itself when it is sampled on the boundary edge. The bench drives inputs just after the falling edge and advances its reference model on the rising edge. It compares every output at the following falling edge, one clock after the stimulus, so each check falls in the cycle where its result is due. The sweep covers a jump to every table address, with the request placed at every bit position of the word.

// File: rtl/sws_pkg.sv
// Shared helpers for the serial word source.
// Assumes word widths of 64 bits or fewer.
package sws_pkg;

    // Table content formula: ((i*157+59) ^ (i << w/2)) mod 2^w
    function automatic logic [63:0] table_word(input int unsigned idx, input int unsigned w);
        logic [63:0] v;
        v = 64'(idx) * 64'd157 + 64'd59;
        v = v ^ (64'(idx) << (w / 2));
        if (w < 64) v = v & ((64'd1 << w) - 64'd1);
        return v;
    endfunction

endpackage

// File: rtl/sws_table.sv
// Read-only word table, filled by formula at elaboration.
// Assumes an asynchronous read; the consumer registers the data.
module sws_table #(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    import sws_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] words [DEPTH];

    // One constant entry per address
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign words[g] = WORD_W'(table_word(g, WORD_W));
    end

    // Combinational read port
    assign rd_data = words[rd_addr];
endmodule

// File: rtl/sws_bit_ctr.sv
// Bit position counter. It marks the boundary (load) clock and the first-bit clock.
// Reset parks it on the last position, so the first active edge loads a word.
module sws_bit_ctr #(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic load,
    output logic first
);
    localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BW-1:0] LAST = BW'(WORD_W - 1);

    logic [BW-1:0] pos_q;

    // Advance the position, wrapping from LAST back to 0
    always_ff @(posedge clk) begin
        if (!rst_n)            pos_q <= LAST;
        else if (pos_q == LAST) pos_q <= '0;
        else                    pos_q <= pos_q + BW'(1);
    end

    assign load  = (pos_q == LAST);
    assign first = (pos_q == '0);

    // R3
    pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> first);
    // R3
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (pos_q == $past(pos_q) + BW'(1)));
endmodule

// File: rtl/sws_addr_seq.sv
// Table address sequencer. It picks the fetch address for each boundary and
// remembers a jump until the boundary arrives. Assumes `load` marks the boundary.
module sws_addr_seq #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              jump_req,
    input  logic [ADDR_W-1:0] jump_addr,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [ADDR_W-1:0] next_q, tgt_q, cur_q;
    logic              pend_q, started_q;

    // Fetch source priority: live request, then pending request, then sequential
    always_comb begin
        if (jump_req)    fetch_addr = jump_addr;
        else if (pend_q) fetch_addr = tgt_q;
        else             fetch_addr = next_q;
    end

    // Pointer update on each boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            next_q <= '0;
        end else if (load) begin
            cur_q  <= fetch_addr;
            next_q <= fetch_addr + ADDR_W'(1);
        end
    end

    // Remember the latest jump seen between boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            tgt_q  <= '0;
        end else if (load) begin
            pend_q <= 1'b0;
        end else if (jump_req) begin
            pend_q <= 1'b1;
            tgt_q  <= jump_addr;
        end
    end

    // Marks that at least one word has been fetched since reset
    always_ff @(posedge clk) begin
        if (!rst_n)    started_q <= 1'b0;
        else if (load) started_q <= 1'b1;
    end

    assign cur_addr = cur_q;

    // R4
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && started_q && !jump_req && !pend_q) |=> (cur_q == $past(cur_q) + ADDR_W'(1)));
    // R7
    jump_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && jump_req) |=> (cur_q == $past(jump_addr)));
    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cur_q));
endmodule

// File: rtl/sws_piso.sv
// Parallel-in serial-out shift register, LSB first.
// Loads on the boundary clock and shifts right on every other clock.
module sws_piso #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    output logic              dout
);
    logic [WORD_W-1:0] sr_q;

    // Load a fresh word or shift toward bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)    sr_q <= '0;
        else if (load) sr_q <= din;
        else           sr_q <= sr_q >> 1;
    end

    assign dout = sr_q[0];

    // R2
    load_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dout == $past(din[0])));
endmodule

// File: rtl/serial_word_source.sv
// Serial word sequencer top. Serialises table words back to back,
// LSB first, with a frame strobe on bit 0 and a jump at word boundaries.
// Assumes WORD_W >= 2 and WORD_W <= 64.
module serial_word_source #(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jump_req,
    input  logic [ADDR_W-1:0] jump_addr,
    output logic              ser_bit,
    output logic              frame,
    output logic [ADDR_W-1:0] cur_addr
);
    logic              load, first;
    logic [ADDR_W-1:0] fetch_addr;
    logic [WORD_W-1:0] word;

    sws_bit_ctr #(.WORD_W(WORD_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(load), .first(first)
    );

    sws_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .jump_req(jump_req),
        .jump_addr(jump_addr), .fetch_addr(fetch_addr), .cur_addr(cur_addr)
    );

    sws_table #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_table (
        .rd_addr(fetch_addr), .rd_data(word)
    );

    sws_piso #(.WORD_W(WORD_W)) u_piso (
        .clk(clk), .rst_n(rst_n), .load(load), .din(word), .dout(ser_bit)
    );

    assign frame = first;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cur_addr == '0 && !frame && !ser_bit));
    // R3
    frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame |=> !frame);
    // R3
    frame_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> frame);
endmodule

// File: tb/test_serial_word_source.sv
module test_serial_word_source;
    localparam int CLK_P = 10;
    localparam int AW = 5;
    localparam int DEPTH = 1 << AW;
    localparam int NW = 8;
    localparam int WW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic jump_req = 1'b0;
    logic [AW-1:0] jump_addr = '0;
    logic ser_bit, frame, w_ser, w_frame;
    logic [AW-1:0] cur_addr, w_addr;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state, narrow and wide
    int m_pos = NW - 1, m_addr = 0, m_next = 0, m_tgt = 0;
    bit m_live = 0, m_pend = 0;
    int w_pos = WW - 1, w_a = 0;
    bit w_live = 0;

    always #(CLK_P / 2) clk = ~clk;

    serial_word_source #(.WORD_W(NW), .ADDR_W(AW)) i_serial_word_source (
        .clk(clk), .rst_n(rst_n), .jump_req(jump_req), .jump_addr(jump_addr),
        .ser_bit(ser_bit), .frame(frame), .cur_addr(cur_addr)
    );

    serial_word_source #(.WORD_W(WW), .ADDR_W(AW)) i_wide (
        .clk(clk), .rst_n(rst_n), .jump_req(1'b0), .jump_addr('0),
        .ser_bit(w_ser), .frame(w_frame), .cur_addr(w_addr)
    );

    function automatic longint word_of(input int i, input int w);
        longint v;
        v = longint'(i) * 157 + 59;
        v = v ^ (longint'(i) << (w / 2));
        return v & ((longint'(1) << w) - 1);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        if (!m_live) begin
            chk("R1 addr", cur_addr, 0);
            chk("R1 frame", frame, 0);
            chk("R1 ser", ser_bit, 0);
        end else begin
            chk("R3 frame", frame, (m_pos == 0) ? 1 : 0);
            chk("R2 R8 ser", ser_bit, (word_of(m_addr, NW) >> m_pos) & 1);
            chk((m_addr == 0) ? "R9 addr" : tag, cur_addr, m_addr);
        end
        if (!w_live) begin
            chk("R1 wide frame", w_frame, 0);
        end else begin
            chk("R10 wide frame", w_frame, (w_pos == 0) ? 1 : 0);
            chk("R10 wide ser", w_ser, (word_of(w_a, WW) >> w_pos) & 1);
            chk("R10 wide addr", w_addr, w_a);
            if (w_pos == 0) chk("R10 aligned", frame, 1);
        end
    endtask

    task automatic model(input bit rn, input bit jr, input int ja);
        if (!rn) begin
            m_live = 0; m_pos = NW - 1; m_addr = 0; m_next = 0; m_pend = 0;
            w_live = 0; w_pos = WW - 1; w_a = 0;
            return;
        end
        if (m_pos == NW - 1) begin
            m_addr = jr ? ja : (m_pend ? m_tgt : m_next);
            m_next = (m_addr + 1) % DEPTH;
            m_pend = 0; m_pos = 0; m_live = 1;
        end else begin
            m_pos++;
            if (jr) begin m_pend = 1; m_tgt = ja; end
        end
        if (w_pos == WW - 1) begin
            w_a = w_live ? (w_a + 1) % DEPTH : 0;
            w_pos = 0; w_live = 1;
        end else begin
            w_pos++;
        end
    endtask

    task automatic cyc(input bit rn, input bit jr, input int ja, input string tag);
        @(negedge clk);
        compare(tag);
        rst_n = rn; jump_req = jr; jump_addr = AW'(ja);
        @(posedge clk);
        model(rn, jr, ja);
    endtask

    initial begin
        // R1: reset state
        repeat (3) cyc(0, 0, 0, "R1");
        // R4 R9: free run past the table end
        repeat (DEPTH * NW + 40) cyc(1, 0, 0, "R4 R5 addr");
        // R6 R7: jump to every address from every bit position
        for (int t = 0; t < DEPTH; t++) begin
            while (m_pos != (t % NW)) cyc(1, 0, 0, "R4 R5 addr");
            cyc(1, 1, t, ((t % NW) == NW - 1) ? "R7 addr" : "R6 addr");
            repeat (2 * NW) cyc(1, 0, 0, ((t % NW) == NW - 1) ? "R7 addr" : "R6 addr");
        end
        // R6: latest of two requests wins
        while (m_pos != 1) cyc(1, 0, 0, "R4 R5 addr");
        cyc(1, 1, 5, "R6 addr");
        cyc(1, 1, 20, "R6 addr");
        repeat (2 * NW) cyc(1, 0, 0, "R6 addr");
        // R7: boundary request overrides a pending one
        while (m_pos != NW - 2) cyc(1, 0, 0, "R4 R5 addr");
        cyc(1, 1, 9, "R7 addr");
        cyc(1, 1, 27, "R7 addr");
        repeat (2 * NW) cyc(1, 0, 0, "R7 addr");
        // R1: reset in mid run, then restart
        while (m_pos != 3) cyc(1, 0, 0, "R4 R5 addr");
        repeat (2) cyc(0, 1, 7, "R1");
        repeat (3 * WW) cyc(1, 0, 0, "R4 R5 addr");
        @(negedge clk);
        compare("R4 R5 addr");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule